// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture

This block is an on-chip logic analyzer core. Each clock it can store one word of a probe bus into an internal sample memory. Storage is controlled by a trigger built from a set of match units. Each match unit compares a separate trigger bus against a programmed reference using a selectable function. The unit results are merged in one of two ways. The simple mode uses a single AND or OR with an optional final inversion. The sequencer mode steps through up to a configured number of levels, and each level waits for one chosen match unit.

Capture works in one of two ways. In window mode, one trigger stores a fixed number of samples. In repeated mode, every trigger that arrives while the core is waiting stores a burst of N samples. In both modes the total never exceeds the memory depth. Three command pulses control the core: arm a triggered capture, stop, and force an unconditional capture. A done flag, a stored-sample count and a synchronous read port let a host fetch the samples in the order they were taken.

Top module: `la_capture_top`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o and done_o are 0 and count_o is 0.
- R2: Each match unit compares trig_i, as an unsigned number, with its reference value. The function codes are: 0 equal, 1 not equal, 2 less than, 3 greater than, 4 less or equal, 5 greater or equal, 6 always true, 7 never true. Unit k uses reference bits [16k+15:16k] and code bits [3k+2:3k].
- R3: With seq_mode_i low, the trigger is the AND of all unit results (trig_or_i=0) or their OR (trig_or_i=1), then inverted when trig_inv_i=1.
- R4: With seq_mode_i high, the sequencer starts at level 0 when the core is armed. Level k waits for the unit whose index is in seq_sel_i bits [2k+1:2k] and then moves to level k+1. The trigger fires in the cycle in which the level given by seq_last_i sees its unit match. Matches of the wrong unit do not advance the sequencer.
- R5: In window mode (cap_rep_i=0), the probe value from the trigger cycle is stored at address 0. The following cycles are stored at consecutive addresses until the window length is reached. Then done_o rises and busy_o falls.
- R6: In repeated mode (cap_rep_i=1), each trigger stores a burst of N consecutive samples that starts with the trigger cycle. A trigger that arrives during a burst is ignored. After a burst the core waits for the next trigger, and busy_o stays high.
- R7: count_o never exceeds the memory depth. It rises by at most one per cycle. When the memory is full, capture ends with done_o high.
- R8: A stop pulse ends any capture at once. The sample of that cycle is not stored, done_o goes high and count_o keeps its value.
- R9: A force pulse clears the count. The core then stores a window of samples, starting with the probe value of the cycle after the pulse, without any trigger, and then sets done_o.
- R10: rd_data_o shows the word stored at rd_addr_i one cycle after the address is presented.
- R11: A length of 0, or a length above the depth, captures the full depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | PROBE_W | Data sampled into memory |
| trig_i | input | TRIG_W | Bus watched by the match units |
| mu_val_i | input | NUM_MU*TRIG_W | Reference value of each match unit |
| mu_func_i | input | NUM_MU*3 | Function code of each match unit |
| trig_or_i | input | 1 | Simple mode: 1 = OR of units, 0 = AND |
| trig_inv_i | input | 1 | Simple mode: invert combined result |
| seq_mode_i | input | 1 | 1 = sequencer trigger, 0 = simple trigger |
| seq_last_i | input | clog2(MAX_LVL) | Index of the final sequencer level |
| seq_sel_i | input | MAX_LVL*clog2(NUM_MU) | Unit selected by each level |
| cap_rep_i | input | 1 | 1 = repeated N-sample mode, 0 = window mode |
| cap_len_i | input | clog2(DEPTH)+1 | Window length or burst length N |
| cmd_arm_i | input | 1 | Arm a triggered capture (pulse) |
| cmd_stop_i | input | 1 | Stop capture (pulse) |
| cmd_force_i | input | 1 | Start unconditional capture (pulse) |
| rd_addr_i | input | clog2(DEPTH) | Read address |
| rd_data_o | output | PROBE_W | Stored sample, one cycle after the address |
| busy_o | output | 1 | Armed or capturing |
| done_o | output | 1 | Capture finished |
| count_o | output | clog2(DEPTH)+1 | Number of samples stored |

## Verification
A wrong level in the sequencer, or a wrong match result, shows up as the wrong sample at address 0, or as count_o still at zero. This is visible a few cycles after the stimulus. A burst counter that is off by one changes count_o at the end of each burst, and it breaks the run of consecutive probe values at the burst boundary on readback. A write pointer that is wrong shows up when the memory fills: either count_o goes past the depth or done_o stays low. The probe is driven with a counting pattern, so every stored word names the exact cycle it came from.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [2:0] {
        FN_EQ    = 3'd0,
        FN_NE    = 3'd1,
        FN_LT    = 3'd2,
        FN_GT    = 3'd3,
        FN_LE    = 3'd4,
        FN_GE    = 3'd5,
        FN_ANY   = 3'd6,
        FN_NONE  = 3'd7
    } match_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    localparam int FN_W = 3;

endpackage

// File: rtl/la_match_unit.sv
module la_match_unit
    import la_pkg::*;
#(
    parameter int TRIG_W = 16
) (
    input  logic [TRIG_W-1:0] trig_i,
    input  logic [TRIG_W-1:0] ref_i,
    input  match_fn_e         fn_i,
    output logic              hit_o
);

    always_comb begin
        unique case (fn_i)
            FN_EQ:   hit_o = (trig_i == ref_i);
            FN_NE:   hit_o = (trig_i != ref_i);
            FN_LT:   hit_o = (trig_i <  ref_i);
            FN_GT:   hit_o = (trig_i >  ref_i);
            FN_LE:   hit_o = (trig_i <= ref_i);
            FN_GE:   hit_o = (trig_i >= ref_i);
            FN_ANY:  hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/la_trig_combine.sv
module la_trig_combine #(
    parameter int NUM_MU  = 4,
    parameter int MAX_LVL = 4,
    localparam int SEL_W  = $clog2(NUM_MU),
    localparam int LVL_W  = $clog2(MAX_LVL)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_MU-1:0]        hits_i,
    input  logic                     or_mode_i,
    input  logic                     invert_i,
    input  logic                     seq_mode_i,
    input  logic [LVL_W-1:0]         seq_last_i,
    input  logic [MAX_LVL*SEL_W-1:0] seq_sel_i,
    input  logic                     en_i,
    input  logic                     clr_i,
    output logic                     fire_o
);

    logic [LVL_W-1:0] lvl_q;
    logic [SEL_W-1:0] cur_sel;
    logic             cur_hit;
    logic             simple_hit;
    logic             seq_fire;

    assign simple_hit = (or_mode_i ? (|hits_i) : (&hits_i)) ^ invert_i;

    assign cur_sel  = seq_sel_i[lvl_q*SEL_W +: SEL_W];
    assign cur_hit  = hits_i[cur_sel];
    assign seq_fire = cur_hit && (lvl_q == seq_last_i);

    assign fire_o = en_i && (seq_mode_i ? seq_fire : simple_hit);

    always_ff @(posedge clk) begin
        if (rst || clr_i || !en_i || !seq_mode_i) begin
            lvl_q <= '0;
        end else if (cur_hit) begin
            lvl_q <= (lvl_q == seq_last_i) ? '0 : lvl_q + 1'b1;
        end
    end

endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_o <= mem_q[raddr_i];
    end

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_pkg::*;
#(
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic              rep_mode_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              cmd_arm_i,
    input  logic              cmd_stop_i,
    input  logic              cmd_force_i,
    output logic              armed_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    cap_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rem_q;
    logic             one_shot_q;
    logic [CNT_W-1:0] len_eff;
    logic             any_cmd;
    logic             full_next;
    logic             burst_end;

    assign len_eff   = (len_i == '0 || len_i > DEPTH_C) ? DEPTH_C : len_i;
    assign any_cmd   = cmd_arm_i || cmd_stop_i || cmd_force_i;
    assign we_o      = !any_cmd && ((st_q == ST_ARMED && fire_i) || st_q == ST_CAPT);
    assign full_next = (cnt_q == LAST_C);
    assign burst_end = (st_q == ST_ARMED) ? (len_eff == ONE_C) : (rem_q == ONE_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            rem_q      <= '0;
            one_shot_q <= 1'b0;
        end else if (cmd_stop_i) begin
            st_q <= ST_DONE;
        end else if (cmd_arm_i) begin
            st_q       <= ST_ARMED;
            cnt_q      <= '0;
            one_shot_q <= !rep_mode_i;
        end else if (cmd_force_i) begin
            st_q       <= ST_CAPT;
            cnt_q      <= '0;
            rem_q      <= len_eff;
            one_shot_q <= 1'b1;
        end else if (we_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (burst_end || full_next) begin
                st_q <= (one_shot_q || full_next) ? ST_DONE : ST_ARMED;
            end else if (st_q == ST_ARMED) begin
                st_q  <= ST_CAPT;
                rem_q <= len_eff - 1'b1;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign armed_o = (st_q == ST_ARMED);
    assign waddr_o = cnt_q[ADDR_W-1:0];
    assign busy_o  = (st_q == ST_ARMED) || (st_q == ST_CAPT);
    assign done_o  = (st_q == ST_DONE);
    assign count_o = cnt_q;

endmodule

// File: rtl/la_capture_top.sv
module la_capture_top
    import la_pkg::*;
#(
    parameter int PROBE_W = 16,
    parameter int TRIG_W  = 16,
    parameter int NUM_MU  = 4,
    parameter int MAX_LVL = 4,
    parameter int DEPTH   = 1024
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [PROBE_W-1:0]                       probe_i,
    input  logic [TRIG_W-1:0]                        trig_i,
    input  logic [NUM_MU*TRIG_W-1:0]                 mu_val_i,
    input  logic [NUM_MU*3-1:0]                      mu_func_i,
    input  logic                                     trig_or_i,
    input  logic                                     trig_inv_i,
    input  logic                                     seq_mode_i,
    input  logic [$clog2(MAX_LVL)-1:0]               seq_last_i,
    input  logic [MAX_LVL*$clog2(NUM_MU)-1:0]        seq_sel_i,
    input  logic                                     cap_rep_i,
    input  logic [$clog2(DEPTH):0]                   cap_len_i,
    input  logic                                     cmd_arm_i,
    input  logic                                     cmd_stop_i,
    input  logic                                     cmd_force_i,
    input  logic [$clog2(DEPTH)-1:0]                 rd_addr_i,
    output logic [PROBE_W-1:0]                       rd_data_o,
    output logic                                     busy_o,
    output logic                                     done_o,
    output logic [$clog2(DEPTH):0]                   count_o
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic [NUM_MU-1:0] hits;
    logic              fire;
    logic              armed;
    logic              we;
    logic [ADDR_W-1:0] waddr;

    for (genvar g = 0; g < NUM_MU; g++) begin : g_mu
        la_match_unit #(.TRIG_W(TRIG_W)) u_mu (
            .trig_i (trig_i),
            .ref_i  (mu_val_i[g*TRIG_W +: TRIG_W]),
            .fn_i   (match_fn_e'(mu_func_i[g*FN_W +: FN_W])),
            .hit_o  (hits[g])
        );
    end

    la_trig_combine #(.NUM_MU(NUM_MU), .MAX_LVL(MAX_LVL)) u_comb (
        .clk        (clk),
        .rst        (rst),
        .hits_i     (hits),
        .or_mode_i  (trig_or_i),
        .invert_i   (trig_inv_i),
        .seq_mode_i (seq_mode_i),
        .seq_last_i (seq_last_i),
        .seq_sel_i  (seq_sel_i),
        .en_i       (armed),
        .clr_i      (cmd_arm_i || cmd_stop_i || cmd_force_i),
        .fire_o     (fire)
    );

    la_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .fire_i      (fire),
        .rep_mode_i  (cap_rep_i),
        .len_i       (cap_len_i),
        .cmd_arm_i   (cmd_arm_i),
        .cmd_stop_i  (cmd_stop_i),
        .cmd_force_i (cmd_force_i),
        .armed_o     (armed),
        .we_o        (we),
        .waddr_o     (waddr),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .count_o     (count_o)
    );

    la_sample_mem #(.DATA_W(PROBE_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (probe_i),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_arm_i,
    input logic             cmd_stop_i,
    input logic             cmd_force_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && count_o == '0));

    // R7
    a_r7_count_cap: assert property (@(posedge clk) disable iff (rst)
        count_o <= DEPTH_C);

    // R7
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (!cmd_arm_i && !cmd_force_i) |=>
            (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

    // R8
    a_r8_stop_done: assert property (@(posedge clk) disable iff (rst)
        cmd_stop_i |=> (done_o && !busy_o && $stable(count_o)));

    // R9
    a_r9_force_start: assert property (@(posedge clk) disable iff (rst)
        (cmd_force_i && !cmd_stop_i && !cmd_arm_i) |=> (busy_o && count_o == '0));

    // R5
    a_r5_done_frozen: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cmd_arm_i && !cmd_force_i) |=> (done_o && $stable(count_o)));

    // R5
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

endmodule

bind la_capture_top la_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_arm_i   (cmd_arm_i),
    .cmd_stop_i  (cmd_stop_i),
    .cmd_force_i (cmd_force_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .count_o     (count_o)
);

// File: tb/sim_la_capture_top.sv
`timescale 1ns/1ps
module sim_la_capture_top;

    localparam int DEPTH = 32;
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   probe_i = 16'h0100;
    logic [15:0]   trig_i = '0;
    logic [63:0]   mu_val_i = '0;
    logic [11:0]   mu_func_i = '0;
    logic          trig_or_i = 1'b0;
    logic          trig_inv_i = 1'b0;
    logic          seq_mode_i = 1'b0;
    logic [1:0]    seq_last_i = '0;
    logic [7:0]    seq_sel_i = '0;
    logic          cap_rep_i = 1'b0;
    logic [CW-1:0] cap_len_i = '0;
    logic          cmd_arm_i = 1'b0;
    logic          cmd_stop_i = 1'b0;
    logic          cmd_force_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [15:0]   rd_data_o;
    logic          busy_o;
    logic          done_o;
    logic [CW-1:0] count_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;
    always @(posedge clk) probe_i <= probe_i + 16'd1;

    la_capture_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .probe_i(probe_i), .trig_i(trig_i),
        .mu_val_i(mu_val_i), .mu_func_i(mu_func_i),
        .trig_or_i(trig_or_i), .trig_inv_i(trig_inv_i),
        .seq_mode_i(seq_mode_i), .seq_last_i(seq_last_i), .seq_sel_i(seq_sel_i),
        .cap_rep_i(cap_rep_i), .cap_len_i(cap_len_i),
        .cmd_arm_i(cmd_arm_i), .cmd_stop_i(cmd_stop_i), .cmd_force_i(cmd_force_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o), .done_o(done_o), .count_o(count_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk) cmd_arm_i = 1'b1;
        @(negedge clk) cmd_arm_i = 1'b0;
    endtask

    task automatic read_word(input int addr, output logic [15:0] val);
        @(negedge clk) rd_addr_i = AW'(addr);
        @(negedge clk) val = rd_data_o;
    endtask

    task automatic set_unit(input int k, input logic [15:0] v, input logic [2:0] fn);
        mu_val_i[k*16 +: 16] = v;
        mu_func_i[k*3 +: 3]  = fn;
    endtask

    task automatic check_run(input string tag, input logic [15:0] first, input int n);
        logic [15:0] v;
        for (int i = 0; i < n; i++) begin
            read_word(i, v);
            chk(tag, v, first + 16'(i));
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 count", count_o, 0);
    endtask

    // R2 R3 R5: AND of one EQ unit, window of 5
    task automatic t_window_eq();
        logic [15:0] v0;
        set_unit(0, 16'h1234, 3'd0);
        set_unit(1, 16'h0, 3'd6);
        set_unit(2, 16'h0, 3'd6);
        set_unit(3, 16'h0, 3'd6);
        trig_or_i = 0; trig_inv_i = 0; seq_mode_i = 0;
        cap_rep_i = 0; cap_len_i = CW'(5);
        trig_i = 16'h1235;
        pulse_arm();
        tick(4);
        chk("R2 no match keeps count", count_o, 0);
        chk("R5 busy while armed", busy_o, 1);
        @(negedge clk) begin trig_i = 16'h1234; v0 = probe_i; end
        @(negedge clk) trig_i = 16'h0;
        tick(8);
        chk("R5 done", done_o, 1);
        chk("R5 busy low", busy_o, 0);
        chk("R5 count", count_o, 5);
        check_run("R5 R10 data", v0, 5);
    endtask

    // R2 R3: OR of GT and EQ, inverted
    task automatic t_or_inv();
        logic [15:0] v0, v;
        set_unit(0, 16'h8000, 3'd3);
        set_unit(1, 16'h0001, 3'd0);
        set_unit(2, 16'h0, 3'd7);
        set_unit(3, 16'h0, 3'd7);
        trig_or_i = 1; trig_inv_i = 1;
        cap_len_i = CW'(3);
        trig_i = 16'h0001;
        pulse_arm();
        tick(2);
        @(negedge clk) trig_i = 16'h9000;
        @(negedge clk) trig_i = 16'h0001;
        tick(2);
        chk("R3 inverted OR holds off", count_o, 0);
        @(negedge clk) begin trig_i = 16'h0005; v0 = probe_i; end
        @(negedge clk) trig_i = 16'h0001;
        tick(5);
        chk("R3 inverted OR count", count_o, 3);
        read_word(0, v);
        chk("R3 trigger sample", v, v0);
        trig_or_i = 0; trig_inv_i = 0;
    endtask

    // R2 R3: AND of GE, LE, NE
    task automatic t_and_range();
        logic [15:0] v0, v;
        set_unit(0, 16'h0100, 3'd5);
        set_unit(1, 16'h01FF, 3'd4);
        set_unit(2, 16'h0150, 3'd1);
        set_unit(3, 16'h0, 3'd6);
        cap_len_i = CW'(2);
        trig_i = 16'h00FF;
        pulse_arm();
        @(negedge clk) trig_i = 16'h0150;
        @(negedge clk) trig_i = 16'h0200;
        @(negedge clk) trig_i = 16'h00FF;
        tick(2);
        chk("R2 range rejects", count_o, 0);
        @(negedge clk) begin trig_i = 16'h01FF; v0 = probe_i; end
        @(negedge clk) trig_i = 16'h0;
        tick(4);
        chk("R2 range count", count_o, 2);
        read_word(0, v);
        chk("R2 range sample", v, v0);
    endtask

    // R4: three levels, unit0 -> unit1 -> unit0
    task automatic t_sequencer();
        logic [15:0] v0, v;
        set_unit(0, 16'h000A, 3'd0);
        set_unit(1, 16'h000B, 3'd0);
        set_unit(2, 16'h0, 3'd7);
        set_unit(3, 16'h0, 3'd7);
        seq_mode_i = 1; seq_last_i = 2'd2;
        seq_sel_i = {2'd0, 2'd0, 2'd1, 2'd0};
        cap_len_i = CW'(4);
        trig_i = 16'h0;
        pulse_arm();
        @(negedge clk) trig_i = 16'h000B;
        @(negedge clk) trig_i = 16'h000A;
        @(negedge clk) trig_i = 16'h000A;
        @(negedge clk) trig_i = 16'h000B;
        @(negedge clk) trig_i = 16'h000C;
        @(negedge clk) trig_i = 16'h0;
        chk("R4 no early fire", count_o, 0);
        @(negedge clk) begin trig_i = 16'h000A; v0 = probe_i; end
        @(negedge clk) trig_i = 16'h0;
        tick(6);
        chk("R4 count", count_o, 4);
        chk("R4 done", done_o, 1);
        read_word(0, v);
        chk("R4 final level sample", v, v0);
        seq_mode_i = 0;
    endtask

    // R6 R7: repeated bursts of 4, retrigger ignored, fill memory
    task automatic t_repeat();
        logic [15:0] v1, v2, v3, v;
        set_unit(0, 16'h0007, 3'd0);
        set_unit(1, 16'h0, 3'd6);
        set_unit(2, 16'h0, 3'd6);
        set_unit(3, 16'h0, 3'd6);
        cap_rep_i = 1; cap_len_i = CW'(4);
        trig_i = 16'h0;
        pulse_arm();
        @(negedge clk) begin trig_i = 16'h0007; v1 = probe_i; end
        @(negedge clk) trig_i = 16'h0;
        @(negedge clk) trig_i = 16'h0007;
        @(negedge clk) trig_i = 16'h0;
        tick(3);
        chk("R6 one burst", count_o, 4);
        chk("R6 still busy", busy_o, 1);
        @(negedge clk) begin trig_i = 16'h0007; v2 = probe_i; end
        @(negedge clk) trig_i = 16'h0;
        tick(6);
        chk("R6 two bursts", count_o, 8);
        chk("R6 not done", done_o, 0);
        check_run("R6 burst1", v1, 4);
        for (int i = 0; i < 4; i++) begin
            read_word(4 + i, v);
            chk("R6 burst2", v, v2 + 16'(i));
        end
        @(negedge clk) begin trig_i = 16'h0007; v3 = probe_i; end
        tick(40);
        trig_i = 16'h0;
        chk("R7 full done", done_o, 1);
        chk("R7 count at depth", count_o, DEPTH);
        read_word(8, v);
        chk("R7 continuous start", v, v3);
        read_word(DEPTH - 1, v);
        chk("R7 last slot", v, v3 + 16'(DEPTH - 9));
        cap_rep_i = 0;
    endtask

    // R8 R9 R11: force, stop, clamp
    task automatic t_force_stop();
        logic [15:0] p, v;
        logic [CW-1:0] c;
        cap_len_i = CW'(6);
        @(negedge clk) begin cmd_force_i = 1; p = probe_i; end
        @(negedge clk) cmd_force_i = 0;
        tick(8);
        chk("R9 force count", count_o, 6);
        chk("R9 force done", done_o, 1);
        check_run("R9 force data", p + 16'd1, 6);
        cap_len_i = '0;
        @(negedge clk) cmd_force_i = 1;
        @(negedge clk) cmd_force_i = 0;
        tick(4);
        @(negedge clk) cmd_stop_i = 1;
        @(negedge clk) cmd_stop_i = 0;
        c = count_o;
        chk("R8 stop count", c, 5);
        chk("R8 stop done", done_o, 1);
        tick(3);
        chk("R8 count frozen", count_o, c);
        set_unit(0, 16'h0, 3'd7);
        pulse_arm();
        tick(3);
        @(negedge clk) cmd_stop_i = 1;
        @(negedge clk) cmd_stop_i = 0;
        chk("R8 stop while armed", done_o, 1);
        chk("R8 stop armed count", count_o, 0);
        cap_len_i = CW'(40);
        @(negedge clk) cmd_force_i = 1;
        @(negedge clk) cmd_force_i = 0;
        tick(DEPTH + 4);
        chk("R11 clamp above depth", count_o, DEPTH);
        cap_len_i = '0;
        @(negedge clk) cmd_force_i = 1;
        @(negedge clk) cmd_force_i = 0;
        tick(DEPTH + 4);
        chk("R11 zero means depth", count_o, DEPTH);
        read_word(0, v);
        read_word(DEPTH - 1, p);
        chk("R10 R11 span", p - v, DEPTH - 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_window_eq();
        t_or_inv();
        t_and_range();
        t_sequencer();
        t_repeat();
        t_force_stop();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule